// File: doc/BRIEF.md
# Processor Status Word Register

This block keeps the 16-bit status word of a small processor core. The low half, the user byte, carries five condition flags. The ALU updates these flags after an operation, through a per-flag update mask. The high half, the system byte, carries a trace bit, a supervisor bit and a 3-bit interrupt priority mask. Software can load the whole word through a write port, but only while the core runs in supervisor mode. In user mode the same write reaches the flags alone.

An exception-entry strobe forces supervisor mode and loads the priority mask with the level being taken, all in one clock. A combinational gate compares an incoming interrupt level with the current mask and reports whether the request may be taken. Level 7 cannot be masked. Every control bit and every flag is also brought out on its own pin, for branch evaluation and interrupt gating.

All ports are plain control and status pins. Nothing flows through the block as a stream, so it has no valid/ready handshake and never applies back-pressure. Every input is sampled on each rising clock edge.

Top module: `psw_reg`

## Requirements
- R1: The word layout is trace at bit 15, supervisor at bit 13, priority mask at bits 10:8, and the flags at bits 4:0: X (extend) at 4, N (negative) at 3, Z (zero) at 2, V (overflow) at 1 and C (carry) at 0. Bits 14, 12, 11 and 7:5 always read as 0.
- R2: After reset the word is 0x2700: supervisor 1, mask 7, and every other bit 0.
- R3: The ALU flag vector and its update mask both use the order {X,N,Z,V,C}, with C in bit 0. On a clock with no word write, each flag whose mask bit is 1 takes the ALU value. Each flag whose mask bit is 0 keeps its value.
- R4: The separate flag, trace, supervisor and mask outputs always equal the matching bits of the status word.
- R5: A word write while supervisor is 1 loads every implemented bit from the write data. Reserved bits of the write data are dropped.
- R6: A word write while supervisor is 0 loads only bits 7:0. The system byte is left unchanged.
- R7: When a word write and an ALU update happen in the same cycle, the write data sets the flags and the ALU values are discarded.
- R8: An interrupt request of level L (0 to 7) is accepted when L is greater than the mask, or when L is 7. Level 0 is never accepted unless the mask is 0... and even then, since 0 is not greater than 0, it is not accepted.
- R9: Exception entry sets supervisor to 1 and loads the mask with the given level on the same clock. Trace is kept. Exception entry wins over a concurrent word write for the system byte, but the user byte is still written or updated as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_upd_i | input | 5 | Per-flag update mask {X,N,Z,V,C} |
| alu_flags_i | input | 5 | ALU flag results {X,N,Z,V,C} |
| wr_en_i | input | 1 | Word write strobe |
| wr_data_i | input | 16 | Word write data |
| exc_entry_i | input | 1 | Exception entry strobe |
| exc_level_i | input | 3 | Level loaded into the mask on exception entry |
| irq_level_i | input | 3 | Pending interrupt level, 0 means none |
| psw_o | output | 16 | Full status word |
| flag_x_o | output | 1 | Extend flag |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |
| trace_o | output | 1 | Trace bit |
| super_o | output | 1 | Supervisor bit |
| imask_o | output | 3 | Interrupt priority mask |
| irq_accept_o | output | 1 | Pending interrupt may be taken |

## Verification
The bench first drops the core into user mode with a supervisor write of zero. It then writes all ones. A design that ignored the privilege gate would raise supervisor, trace and the mask, while a correct one sets only the five flags.

It collides a write with a full ALU update, and an exception with a supervisor write. A wrong priority would show the ALU flags, or a mask of 0 taken from the write data, instead of the exception level.

It sweeps every interrupt level against masks of 7, 0, 3 and 6, so an off-by-one compare or a maskable level 7 changes the accept pin. It also writes words with the reserved bits set, to catch reserved bits that leak into the word.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W    = 16;
  localparam int FLAG_N   = 5;
  localparam int MASK_W   = 3;
  localparam int BYTE_W   = 8;
  localparam int BIT_T    = 15;
  localparam int BIT_S    = 13;
  localparam int MASK_LO  = 8;
  localparam int MASK_HI  = MASK_LO + MASK_W - 1;
  localparam logic [PSW_W-1:0] PSW_RESET = 16'h2700;

  typedef enum int {
    FL_C = 0,
    FL_V = 1,
    FL_Z = 2,
    FL_N = 3,
    FL_X = 4
  } flag_idx_e;
endpackage

// File: rtl/psw_flag_unit.sv
module psw_flag_unit #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] upd_i,
  input  logic [NF-1:0] val_i,
  input  logic          wr_en_i,
  input  logic [NF-1:0] wr_val_i,
  output logic [NF-1:0] flags_o
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_o[g] <= 1'b0;
      else if (wr_en_i)    flags_o[g] <= wr_val_i[g];
      else if (upd_i[g])   flags_o[g] <= val_i[g];
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && !upd_i[g]) |=> $stable(flags_o[g])); // R3
    AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en_i && upd_i[g]) |=> (flags_o[g] == $past(val_i[g]))); // R3
  end
endmodule

// File: rtl/psw_sys_unit.sv
module psw_sys_unit #(
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic          wr_trace_i,
  input  logic          wr_super_i,
  input  logic [MW-1:0] wr_mask_i,
  input  logic          exc_i,
  input  logic [MW-1:0] exc_level_i,
  output logic          trace_o,
  output logic          super_o,
  output logic [MW-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trace_o <= 1'b0;
      super_o <= 1'b1;
      mask_o  <= '1;
    end else if (exc_i) begin
      super_o <= 1'b1;
      mask_o  <= exc_level_i;
    end else if (wr_en_i) begin
      trace_o <= wr_trace_i;
      super_o <= wr_super_i;
      mask_o  <= wr_mask_i;
    end
  end

  AST_EXC_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    exc_i |=> (super_o && (mask_o == $past(exc_level_i)))); // R9
  AST_EXC_TRACE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    exc_i |=> $stable(trace_o)); // R9
endmodule

// File: rtl/psw_irq_gate.sv
module psw_irq_gate #(
  parameter int MW = 3
) (
  input  logic [MW-1:0] level_i,
  input  logic [MW-1:0] mask_i,
  output logic          accept_o
);
  logic top_level;
  assign top_level = (level_i == '1);
  assign accept_o  = top_level || (level_i > mask_i);

  always_comb begin
    if (top_level) begin
      AST_TOP_LEVEL_TAKEN: assert (accept_o); // R8
    end
    if (level_i == '0) begin
      AST_LEVEL_ZERO_IDLE: assert (!accept_o); // R8
    end
  end
endmodule

// File: rtl/psw_reg.sv
module psw_reg
  import psw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] alu_upd_i,
  input  logic [FLAG_N-1:0] alu_flags_i,
  input  logic              wr_en_i,
  input  logic [PSW_W-1:0]  wr_data_i,
  input  logic              exc_entry_i,
  input  logic [MASK_W-1:0] exc_level_i,
  input  logic [MASK_W-1:0] irq_level_i,
  output logic [PSW_W-1:0]  psw_o,
  output logic              flag_x_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_v_o,
  output logic              flag_c_o,
  output logic              trace_o,
  output logic              super_o,
  output logic [MASK_W-1:0] imask_o,
  output logic              irq_accept_o
);
  logic [FLAG_N-1:0] flags_q;
  logic              sys_wr_en;
  logic              rsv_unused;

  // System byte is writable only from supervisor mode.
  assign sys_wr_en  = wr_en_i && super_o;
  assign rsv_unused = ^{wr_data_i[14], wr_data_i[12:11], wr_data_i[7:5]};

  psw_flag_unit #(.NF(FLAG_N)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_i    (alu_upd_i),
    .val_i    (alu_flags_i),
    .wr_en_i  (wr_en_i),
    .wr_val_i (wr_data_i[FLAG_N-1:0]),
    .flags_o  (flags_q)
  );

  psw_sys_unit #(.MW(MASK_W)) u_sys (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (sys_wr_en),
    .wr_trace_i  (wr_data_i[BIT_T]),
    .wr_super_i  (wr_data_i[BIT_S]),
    .wr_mask_i   (wr_data_i[MASK_HI:MASK_LO]),
    .exc_i       (exc_entry_i),
    .exc_level_i (exc_level_i),
    .trace_o     (trace_o),
    .super_o     (super_o),
    .mask_o      (imask_o)
  );

  psw_irq_gate #(.MW(MASK_W)) u_irq (
    .level_i  (irq_level_i),
    .mask_i   (imask_o),
    .accept_o (irq_accept_o)
  );

  always_comb begin
    psw_o                  = '0;
    psw_o[BIT_T]           = trace_o;
    psw_o[BIT_S]           = super_o;
    psw_o[MASK_HI:MASK_LO] = imask_o;
    psw_o[FLAG_N-1:0]      = flags_q;
  end

  assign flag_x_o = flags_q[FL_X];
  assign flag_n_o = flags_q[FL_N];
  assign flag_z_o = flags_q[FL_Z];
  assign flag_v_o = flags_q[FL_V];
  assign flag_c_o = flags_q[FL_C];

  AST_USER_WR_SYS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !super_o && !exc_entry_i) |=> $stable(psw_o[PSW_W-1:BYTE_W])); // R6
  AST_WR_OVER_ALU: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (psw_o[FLAG_N-1:0] == $past(wr_data_i[FLAG_N-1:0]))); // R7
  AST_SUPER_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && super_o && !exc_entry_i) |=>
      (imask_o == $past(wr_data_i[MASK_HI:MASK_LO]) && trace_o == $past(wr_data_i[BIT_T]))); // R5
endmodule

// File: tb/psw_reg_tb.sv
module psw_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  alu_upd = '0, alu_flags = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        exc_entry = 1'b0;
  logic [2:0]  exc_level = '0, irq_level = '0;
  logic [15:0] psw;
  logic        fx, fn, fz, fv, fc, tr, sp, acc;
  logic [2:0]  imask;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  psw_reg dut_i (
    .clk(clk), .rst_n(rst_n), .alu_upd_i(alu_upd), .alu_flags_i(alu_flags),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .exc_entry_i(exc_entry),
    .exc_level_i(exc_level), .irq_level_i(irq_level), .psw_o(psw),
    .flag_x_o(fx), .flag_n_o(fn), .flag_z_o(fz), .flag_v_o(fv), .flag_c_o(fc),
    .trace_o(tr), .super_o(sp), .imask_o(imask), .irq_accept_o(acc)
  );

  // {upd[5], flags[5], wr, wdata[16], exc, lvl[3], expected word[16]}
  localparam int NV = 10;
  localparam logic [46:0] VEC [0:NV-1] = '{
    {5'b11111, 5'b10101, 1'b0, 16'h0000, 1'b0, 3'd0, 16'h2715},
    {5'b00011, 5'b01010, 1'b0, 16'h0000, 1'b0, 3'd0, 16'h2716},
    {5'b00000, 5'b00000, 1'b1, 16'hFFFF, 1'b0, 3'd0, 16'hA71F},
    {5'b00000, 5'b00000, 1'b1, 16'h0000, 1'b0, 3'd0, 16'h0000},
    {5'b00000, 5'b00000, 1'b1, 16'hFFFF, 1'b0, 3'd0, 16'h001F},
    {5'b00000, 5'b00000, 1'b1, 16'h2700, 1'b0, 3'd0, 16'h0000},
    {5'b11111, 5'b11111, 1'b1, 16'h0003, 1'b0, 3'd0, 16'h0003},
    {5'b00100, 5'b00100, 1'b0, 16'h0000, 1'b1, 3'd5, 16'h2507},
    {5'b00000, 5'b00000, 1'b1, 16'h8009, 1'b1, 3'd3, 16'h2309},
    {5'b10001, 5'b10000, 1'b0, 16'h0000, 1'b0, 3'd0, 16'h2318}
  };
  localparam string VTAG [0:NV-1] = '{
    "R3 all flags", "R3 partial mask", "R5 super write", "R5 super clears",
    "R6 user write", "R6 user sys hold", "R7 write over alu",
    "R9 exc entry", "R9 exc over write", "R3 after exc"
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_word(input string tag, input logic [15:0] exp);
    chk(tag, {16'h0, psw}, {16'h0, exp});
    chk("R4 decoded pins", {23'h0, tr, sp, imask, fx, fn, fz, fv, fc},
        {23'h0, exp[15], exp[13], exp[10:8], exp[4:0]});
    chk("R1 reserved zero", {16'h0, psw & 16'h58E0}, 32'h0);
  endtask

  task automatic sup_write(input logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic sweep(input logic [2:0] m);
    for (int l = 0; l < 8; l++) begin
      irq_level = 3'(l);
      #1;
      chk($sformatf("R8 mask %0d level %0d", m, l), {31'h0, acc},
          {31'h0, (l > int'(m)) || (l == 7)});
    end
    irq_level = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_word("R2 reset", 16'h2700);
    sweep(3'd7);

    for (int i = 0; i < NV; i++) begin
      {alu_upd, alu_flags, wr_en, wr_data, exc_entry, exc_level} = VEC[i][46:16];
      @(posedge clk); #1;
      {alu_upd, alu_flags, wr_en, wr_data, exc_entry, exc_level} = '0;
      chk_word($sformatf("%s v%0d", VTAG[i], i), VEC[i][15:0]);
    end

    sup_write(16'h2000); chk_word("R5 mask zero", 16'h2000); sweep(3'd0);
    sup_write(16'h2300); chk_word("R5 mask three", 16'h2300); sweep(3'd3);
    sup_write(16'h2600); chk_word("R5 mask six", 16'h2600); sweep(3'd6);

    alu_upd = 5'b00000; alu_flags = 5'b11111;
    @(posedge clk); #1;
    alu_flags = '0;
    chk_word("R3 zero mask holds", 16'h2600);

    #2 rst_n = 1'b0;
    #1 chk_word("R2 async reset", 16'h2700);
    @(posedge clk); #1 rst_n = 1'b1;
    @(posedge clk); #1 chk_word("R2 after release", 16'h2700);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule